// File: doc/BRIEF.md
# Cartridge Host-to-Coprocessor Write Mailbox

This block lets a console host CPU hand short 4-bit messages to a coprocessor sitting on the same cartridge. The coprocessor is periodically tied up with time-critical lockout traffic. During those periods it cannot listen, so the host cannot simply write at any time. The host first asks for attention by setting the top bit of a spare cartridge bank register. Once the mailbox is armed, host writes to the low half of the address space with A13 high place their low nibble into a small queue. The coprocessor drains that queue through a valid/ready stream.

Two handshakes are offered. The host can read the mailbox and look for a ready code in the upper nibble. The lower nibble of the same read echoes the last nibble taken, so the host can confirm that a write stuck. The block also drives an active-low host interrupt while it is armed and free. That interrupt opens a bounded transfer window of `WIN_CYCLES` clock cycles, about 60 µs at the default.

Back-pressure rules: `nib_valid` is high whenever the queue holds an entry, and `nib_data` shows the oldest entry. An entry leaves on a clock edge where both `nib_valid` and `nib_ready` are high. While `nib_ready` is low, `nib_valid` and `nib_data` hold. The host side has no back-pressure. A write that arrives while the queue is full is dropped and recorded.

Top module: `cart_mailbox`

## Requirements
- R1: After reset `host_irq_n` is 1, `nib_valid` is 0, `host_rdata` is 8'h00, `drop_flag` is 0 and the mailbox is disarmed.
- R2: A bank write is a bus cycle with `bus_valid` 1, `bus_rnw` 0 and `bus_addr_hi[2]` (A15) 1. Its `bus_wdata[7]` sets (1) or clears (0) the arm state at that edge. Clearing also drops the interrupt and clears `drop_flag`.
- R3: A mailbox write is a bus cycle with `bus_valid` 1, `bus_rnw` 0, `bus_addr_hi[2]` (A15) 0 and `bus_addr_hi[0]` (A13) 1. It is taken only while armed, and it takes `bus_wdata[3:0]`. A write with A13 low, or while disarmed, changes no output.
- R4: A mailbox write in a cycle where `cop_busy` is 1 is not taken. It leaves the queue, `drop_flag` and `host_rdata[3:0]` unchanged.
- R5: `host_irq_n` is driven from a register. After each edge, it is 0 exactly when the block is armed, `cop_busy` was 0 at that edge and the window has not expired.
- R6: `host_irq_n` stays low for at most `WIN_CYCLES` consecutive cycles. After the window expires it stays high until a new bank write with bit 7 set, which restarts the window. A `cop_busy` pulse drops the interrupt and restarts the count.
- R7: Taken nibbles enter a `DEPTH`-entry (default 4) first-in first-out queue. `nib_valid` rises in the cycle after the accepting edge, and entries leave in arrival order.
- R8: A write that would be taken while the queue already holds `DEPTH` entries is dropped, even if an entry leaves at the same edge. It sets `drop_flag`, which stays 1 until a disarming bank write or reset.
- R9: `host_rdata[7:4]` is 4'hA while armed with `cop_busy` 0, and 4'h0 otherwise. `host_rdata[3:0]` is the last nibble taken (4'h0 after reset). The upper nibble follows `cop_busy` in the same cycle.
- R10: While `nib_valid` is 1 and `nib_ready` is 0, `nib_valid` and `nib_data` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One-cycle strobe marking a host bus access |
| bus_rnw | input | 1 | 1 = host read, 0 = host write |
| bus_addr_hi | input | 3 | Host address bits {A15, A14, A13} |
| bus_wdata | input | 8 | Host write data |
| cop_busy | input | 1 | Coprocessor is occupied with lockout traffic |
| host_irq_n | output | 1 | Active-low interrupt to the host |
| host_rdata | output | 8 | Mailbox readback: {status code, last taken nibble} |
| nib_valid | output | 1 | Queue holds an entry for the coprocessor |
| nib_ready | input | 1 | Coprocessor takes the presented entry |
| nib_data | output | 4 | Oldest queued nibble |
| drop_flag | output | 1 | Sticky flag: a write was lost to a full queue |

## Verification
A corrupt arm or window state shows on `host_irq_n` and `host_rdata[7:4]` from the next cycle. A stuck window counter becomes visible only when the window should end, `WIN_CYCLES` cycles after the interrupt falls. A wrong queue pointer or count shows on the first later pop as an out-of-order `nib_data`, a missing `nib_valid`, or a `drop_flag` raised at the wrong fill level. A bad echo register shows on the next readback.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
  localparam nib_t STATUS_IDLE = 4'h0;

  // address bit positions inside bus_addr_hi
  localparam int ADDR_A15 = 2;
  localparam int ADDR_A13 = 0;
  localparam int ARM_BIT  = 7;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic       bus_valid,
  input  logic       bus_rnw,
  input  logic [2:0] bus_addr_hi,
  output logic       bank_wr,
  output logic       box_wr
);
  logic wr_cycle;

  always_comb begin
    wr_cycle = bus_valid & ~bus_rnw;
    bank_wr  = wr_cycle & bus_addr_hi[ADDR_A15];
    box_wr   = wr_cycle & ~bus_addr_hi[ADDR_A15] & bus_addr_hi[ADDR_A13];
  end
endmodule

// File: rtl/mbx_window.sv
module mbx_window #(
  parameter int WIN_CYCLES = 3000,
  localparam int CW = $clog2(WIN_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_wr,
  input  logic          arm_bit,
  input  logic          busy,
  output logic          armed,
  output logic          irq,
  output logic [CW-1:0] win_cnt
);
  logic          armed_q, done_q, irq_q;
  logic [CW-1:0] cnt_q;
  logic          arm_d, rearm, expire, done_d, irq_d;
  logic [CW-1:0] cnt_d;

  always_comb begin
    arm_d  = bank_wr ? arm_bit : armed_q;
    rearm  = bank_wr & arm_bit;
    expire = irq_q & (cnt_q == CW'(WIN_CYCLES - 1));
    if (rearm)       done_d = 1'b0;
    else if (expire) done_d = 1'b1;
    else             done_d = done_q;
    irq_d  = arm_d & ~busy & ~done_d;
    cnt_d  = (irq_q & irq_d & ~rearm) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= arm_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed   = armed_q;
  assign irq     = irq_q;
  assign win_cnt = cnt_q;
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop_ready,
  output logic         full,
  output logic         valid,
  output logic [W-1:0] dout
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] count;
  logic          pop, do_push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (count == NW'(DEPTH));
    valid   = (count != '0);
    pop     = valid & pop_ready;
    do_push = push & ~full;
    dout    = slot_q[rd_ptr];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                slot_q[i] <= '0;
      else if (do_push && wr_ptr == PW'(i))      slot_q[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (pop)     rd_ptr <= nxt(rd_ptr);
      case ({do_push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cart_mailbox.sv
module cart_mailbox
  import mbx_pkg::*;
#(
  parameter int   DEPTH      = 4,
  parameter int   WIN_CYCLES = 3000,
  parameter nib_t READY_CODE = 4'hA,
  localparam int  CW = $clog2(WIN_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       bus_rnw,
  input  logic [2:0] bus_addr_hi,
  input  logic [7:0] bus_wdata,
  input  logic       cop_busy,
  output logic       host_irq_n,
  output logic [7:0] host_rdata,
  output logic       nib_valid,
  input  logic       nib_ready,
  output logic [3:0] nib_data,
  output logic       drop_flag
);
  logic          bank_wr, box_wr, armed, irq, full, accept, disarm;
  logic [CW-1:0] win_cnt;
  nib_t          last_q;
  logic          drop_q;

  mbx_decode u_dec (
    .bus_valid   (bus_valid),
    .bus_rnw     (bus_rnw),
    .bus_addr_hi (bus_addr_hi),
    .bank_wr     (bank_wr),
    .box_wr      (box_wr)
  );

  mbx_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank_wr (bank_wr),
    .arm_bit (bus_wdata[ARM_BIT]),
    .busy    (cop_busy),
    .armed   (armed),
    .irq     (irq),
    .win_cnt (win_cnt)
  );

  assign accept = box_wr & armed & ~cop_busy;
  assign disarm = bank_wr & ~bus_wdata[ARM_BIT];

  mbx_fifo #(.W(NIB_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .din       (bus_wdata[NIB_W-1:0]),
    .pop_ready (nib_ready),
    .full      (full),
    .valid     (nib_valid),
    .dout      (nib_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      drop_q <= 1'b0;
    end else begin
      if (accept && !full) last_q <= bus_wdata[NIB_W-1:0];
      if (disarm)                  drop_q <= 1'b0;
      else if (accept && full)     drop_q <= 1'b1;
    end
  end

  assign host_irq_n = ~irq;
  assign host_rdata = {(armed & ~cop_busy) ? READY_CODE : STATUS_IDLE, last_q};
  assign drop_flag  = drop_q;
endmodule

// File: rtl/cart_mailbox_chk.sv
module cart_mailbox_chk #(
  parameter int WIN_CYCLES = 3000,
  localparam int CW = $clog2(WIN_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_rnw,
  input logic [2:0]    bus_addr_hi,
  input logic [7:0]    bus_wdata,
  input logic          cop_busy,
  input logic          host_irq_n,
  input logic [7:0]    host_rdata,
  input logic          nib_valid,
  input logic          nib_ready,
  input logic [3:0]    nib_data,
  input logic          drop_flag,
  input logic          armed,
  input logic [CW-1:0] win_cnt
);
  // R5: interrupt only follows an edge with busy low
  p_irq_after_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq_n |-> (!$past(cop_busy) && armed));

  // R6: window count never reaches the limit while asserted
  p_window_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq_n |-> (win_cnt < CW'(WIN_CYCLES)));

  // R4: echo nibble untouched after a busy cycle
  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cop_busy |=> $stable(host_rdata[3:0]));

  // R8: drop flag sticky unless disarmed
  p_drop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_flag && !(bus_valid && !bus_rnw && bus_addr_hi[2] && !bus_wdata[7]))
      |=> drop_flag);

  // R10: stream holds under back-pressure
  p_stream_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && !nib_ready) |=> (nib_valid && $stable(nib_data)));

  // R9: status nibble only ever shows the ready or idle code
  p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[7:4] == 4'hA) || (host_rdata[7:4] == 4'h0));
endmodule

bind cart_mailbox cart_mailbox_chk #(.WIN_CYCLES(WIN_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rnw(bus_rnw),
  .bus_addr_hi(bus_addr_hi), .bus_wdata(bus_wdata), .cop_busy(cop_busy),
  .host_irq_n(host_irq_n), .host_rdata(host_rdata), .nib_valid(nib_valid),
  .nib_ready(nib_ready), .nib_data(nib_data), .drop_flag(drop_flag),
  .armed(armed), .win_cnt(win_cnt)
);

// File: tb/cart_mailbox_tb_top.sv
`timescale 1ns/1ps
module cart_mailbox_tb_top;
  localparam int TB_WIN = 20;
  localparam int TB_DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_rnw = 1'b1, cop_busy = 1'b0, nib_ready = 1'b0;
  logic [2:0] bus_addr_hi = 3'b000;
  logic [7:0] bus_wdata = 8'h00;
  logic host_irq_n, nib_valid, drop_flag;
  logic [7:0] host_rdata;
  logic [3:0] nib_data;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cart_mailbox #(.DEPTH(TB_DEPTH), .WIN_CYCLES(TB_WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rnw(bus_rnw),
    .bus_addr_hi(bus_addr_hi), .bus_wdata(bus_wdata), .cop_busy(cop_busy),
    .host_irq_n(host_irq_n), .host_rdata(host_rdata), .nib_valid(nib_valid),
    .nib_ready(nib_ready), .nib_data(nib_data), .drop_flag(drop_flag)
  );

  // ---------------- behavioural reference ----------------
  bit m_armed, m_irq, m_ovf, m_spent;
  int m_run;          // cycles the interrupt has been low so far
  int m_last;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_irq = 0; m_ovf = 0; m_spent = 0; m_run = 0; m_last = 0;
      q.delete();
    end else begin
      bit is_bank, is_box, take, new_armed, was_full;
      is_bank = bus_valid && !bus_rnw && bus_addr_hi[2];
      is_box  = bus_valid && !bus_rnw && !bus_addr_hi[2] && bus_addr_hi[0];
      take    = is_box && m_armed && !cop_busy;
      was_full = (q.size() == TB_DEPTH);
      // queue
      if (nib_ready && q.size() > 0) void'(q.pop_front());
      if (take && !was_full) begin q.push_back(int'(bus_wdata[3:0])); m_last = int'(bus_wdata[3:0]); end
      if (is_bank && !bus_wdata[7]) m_ovf = 0;
      else if (take && was_full) m_ovf = 1;
      // interrupt window
      new_armed = is_bank ? bus_wdata[7] : m_armed;
      if (is_bank && bus_wdata[7]) begin m_spent = 0; m_run = 0; end
      else if (m_irq && m_run + 1 >= TB_WIN) m_spent = 1;
      m_armed = new_armed;
      if (m_armed && !cop_busy && !m_spent) begin
        if (m_irq && !(is_bank && bus_wdata[7])) m_run = m_run + 1; else m_run = 0;
        m_irq = 1;
      end else begin
        m_irq = 0; m_run = 0;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FIFO_MBX FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5/R6 irq", int'(host_irq_n), m_irq ? 0 : 1);
    chk("R9 rdata", int'(host_rdata),
        ((m_armed && !cop_busy) ? 8'hA0 : 8'h00) | m_last);
    chk("R7 valid", int'(nib_valid), q.size() > 0 ? 1 : 0);
    if (q.size() > 0) chk("R7 data", int'(nib_data), q[0]);
    chk("R8 drop", int'(drop_flag), m_ovf ? 1 : 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    bus_valid = 1; bus_rnw = 0; bus_addr_hi = a; bus_wdata = d;
    tick();
    bus_valid = 0; bus_rnw = 1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FIFO_MBX FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(host_irq_n), 1);
    chk("R1 valid", int'(nib_valid), 0);
    chk("R1 rdata", int'(host_rdata), 0);
    chk("R1 drop", int'(drop_flag), 0);

    // R3 disarmed write ignored
    host_wr(3'b011, 8'h05);
    tick();
    chk("R3 unarmed", int'(nib_valid), 0);

    // R2 arm
    host_wr(3'b100, 8'h80);
    chk("R2 armed irq", int'(host_irq_n), 0);
    chk("R9 ready code", int'(host_rdata[7:4]), 4'hA);

    // R3 A13 low ignored
    host_wr(3'b010, 8'h07);
    chk("R3 a13 low", int'(nib_valid), 0);

    // R7/R8 fill past depth
    host_wr(3'b011, 8'h01);
    chk("R7 first valid", int'(nib_valid), 1);
    host_wr(3'b001, 8'h02);
    host_wr(3'b011, 8'h03);
    host_wr(3'b011, 8'h04);
    chk("R8 no drop yet", int'(drop_flag), 0);
    host_wr(3'b011, 8'h0E);
    chk("R8 dropped", int'(drop_flag), 1);
    chk("R9 echo", int'(host_rdata[3:0]), 4);

    // R4 busy
    cop_busy = 1;
    @(negedge clk);
    chk("R9 busy code", int'(host_rdata[7:4]), 0);
    host_wr(3'b011, 8'h09);
    chk("R4 echo kept", int'(host_rdata[3:0]), 4);
    chk("R5 busy irq", int'(host_irq_n), 1);
    tick();
    chk("R10 hold", int'(nib_data), 1);
    cop_busy = 0;
    nib_ready = 1;
    repeat (5) tick();
    chk("R7 drained", int'(nib_valid), 0);
    chk("R8 still set", int'(drop_flag), 1);
    nib_ready = 0;

    // R6 window expiry
    repeat (TB_WIN + 4) tick();
    chk("R6 expired", int'(host_irq_n), 1);
    host_wr(3'b100, 8'h80);
    chk("R6 rearm", int'(host_irq_n), 0);
    host_wr(3'b100, 8'h00);
    chk("R2 disarm irq", int'(host_irq_n), 1);
    chk("R2 disarm drop", int'(drop_flag), 0);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      bus_valid   = (r < 45);
      bus_rnw     = (r >= 40);
      bus_addr_hi = (r < 5) ? 3'b100 : 3'($urandom_range(0, 3));
      bus_wdata   = 8'($urandom);
      if (r < 5) bus_wdata[7] = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) cop_busy = ~cop_busy;
      nib_ready   = ($urandom_range(0, 2) == 0);
      tick();
    end
    bus_valid = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule